// File: doc/BRIEF.md
# Tone-Pair Guard Timer and Code Holder

This block sits behind a dual-tone frequency decoder. The decoder raises a flag, `toneHit`, while it recognises a valid tone pair, and it presents the 4-bit key code of that pair on `toneCode`. The block turns that fast, noisy flag into a clean per-digit strobe. It does this with two digital guard timers, which replace an external resistor-capacitor timing network.

A digit is registered only after `toneHit` has stayed high without a break for the tone-present guard time. On that same edge the key code is captured into a holding register and `digitValid` rises. The digit then ends only after `toneHit` has stayed low without a break for the tone-absent guard time, and only then does `digitValid` fall. The effects are:
- A burst that is too short is thrown away.
- A brief drop-out inside a tone is ignored.
- The captured code stays unchanged until the next digit is registered.

Both guard times come in as inputs counted in millisecond ticks. The ticks come from a prescaler of `CLK_PER_MS` clocks. The prescaler restarts whenever a guard run starts, so every guard window is exact.

The held code reaches the pad ring as a three-state bus, expressed as a data/enable pair:
- `busOe` follows `busEnable`.
- `busData` carries the held code while `busEnable` is high, and reads zero while it is low.

Capture continues while the bus is disabled.

Top module: `digitSteer`

## Requirements
- R1: After reset `digitValid` is low and the held code is zero, so `busData` reads 0 once `busEnable` is raised.
- R2: While `digitValid` is low, `digitValid` rises on the clock edge that samples `toneHit` high for the Nth consecutive edge. N = max(1, `presentTicks`) × `CLK_PER_MS`; a `presentTicks` value of 0 acts as 1.
- R3: A high run shorter than N leaves `digitValid` low and the held code unchanged. A single low sample restarts the count from zero.
- R4: The held code is loaded from `toneCode`, as sampled on the edge where `digitValid` rises, on that same edge.
- R5: While `digitValid` is high, a low run shorter than M = max(1, `absentTicks`) × `CLK_PER_MS` edges keeps `digitValid` high. A high sample restarts the absent count.
- R6: `digitValid` falls on the edge that samples `toneHit` low for the Mth consecutive edge. The held code is kept after the fall.
- R7: While `digitValid` is high, changes on `toneCode` do not alter the held code.
- R8: `busOe` equals `busEnable` in the same cycle. `busData` equals the held code when `busEnable` is 1, and equals 4'b0000 when it is 0.
- R9: A digit registered while `busEnable` is low is still captured, and it appears on `busData` as soon as `busEnable` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| toneHit | input | 1 | Signal-condition flag from the decoder |
| toneCode | input | CODE_W | Key code of the pair currently detected |
| presentTicks | input | TICK_W | Tone-present guard time in ms ticks |
| absentTicks | input | TICK_W | Tone-absent guard time in ms ticks |
| busEnable | input | 1 | Output-bus enable |
| digitValid | output | 1 | Delayed steering: a registered digit is held |
| busData | output | CODE_W | Held code when enabled, zero otherwise |
| busOe | output | 1 | Pad drive enable for the code bus |

## Verification
`digitValid` and the held code change on the clock edge that samples the Nth (or Mth) qualifying `toneHit` value; no extra register stage lies in between. `busData` and `busOe` follow `busEnable` combinationally, within the same cycle. The bench therefore drives inputs just after a falling edge and reads outputs just after the following falling edge. Its expected values come from a run-length model that is updated on each rising edge and compared on every cycle. Directed checks sit exactly one cycle before and on the guard boundary, around a single-sample drop-out, and around raising the enable after a digit was captured while the bus was disabled.

// File: rtl/digitSteerPkg.sv
`timescale 1ns/1ps
package digitSteerPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic runStep;   // current sample qualifies for the active guard
    logic runClear;  // restart prescaler and tick counter
    logic loadCode;  // capture the key code
  } steerStrobeT;

  typedef enum logic {IDLE_S, HELD_S} steerStateT;

  localparam int GUARD_PRESENT = 0;
  localparam int GUARD_ABSENT  = 1;
endpackage

// File: rtl/digitSteerData.sv
`timescale 1ns/1ps
module digitSteerData
  import digitSteerPkg::*;
#(
  parameter int CLK_PER_MS = 50000,
  parameter int TICK_W     = 8,
  parameter int CODE_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  steerStrobeT       strobe,
  input  logic [CODE_W-1:0] toneCode,
  input  logic [TICK_W-1:0] presentTicks,
  input  logic [TICK_W-1:0] absentTicks,
  input  logic              busEnable,
  output logic [1:0]        runAtEnd,
  output logic [CODE_W-1:0] codeLatch,
  output logic [CODE_W-1:0] busData,
  output logic              busOe
);
  localparam int SUB_W = $clog2(CLK_PER_MS + 1);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLK_PER_MS - 1);

  logic [SUB_W-1:0]       subCnt;
  logic [TICK_W-1:0]      tickCnt;
  logic                   subEnd;
  logic [1:0][TICK_W-1:0] guardTicks;

  assign subEnd = (subCnt == SUB_LAST);
  assign guardTicks[GUARD_PRESENT] = presentTicks;
  assign guardTicks[GUARD_ABSENT]  = absentTicks;

  // one end-of-window detector per guard; a zero setting behaves as one tick
  for (genvar g = 0; g < 2; g++) begin : gGuard
    logic [TICK_W-1:0] tickLast;
    assign tickLast    = (guardTicks[g] == '0) ? '0 : guardTicks[g] - 1'b1;
    assign runAtEnd[g] = subEnd && (tickCnt == tickLast);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.runClear) begin
      subCnt  <= '0;
      tickCnt <= '0;
    end else if (strobe.runStep) begin
      if (subEnd) begin
        subCnt  <= '0;
        tickCnt <= tickCnt + 1'b1;
      end else begin
        subCnt  <= subCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                codeLatch <= '0;
    else if (strobe.loadCode) codeLatch <= toneCode;
  end

  assign busOe   = busEnable;
  assign busData = busEnable ? codeLatch : '0;
endmodule

// File: rtl/digitSteerCtrl.sv
`timescale 1ns/1ps
module digitSteerCtrl
  import digitSteerPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        toneHit,
  input  logic [1:0]  runAtEnd,
  output steerStrobeT strobe,
  output logic        digitValid
);
  steerStateT state, stateNext;
  logic qualify, runDone;

  always_comb begin
    qualify   = (state == HELD_S) ? !toneHit : toneHit;
    runDone   = qualify && ((state == HELD_S) ? runAtEnd[GUARD_ABSENT]
                                              : runAtEnd[GUARD_PRESENT]);
    strobe.runStep  = qualify;
    strobe.runClear = !qualify || runDone;
    strobe.loadCode = (state == IDLE_S) && runDone;
    stateNext = state;
    if (runDone) stateNext = (state == IDLE_S) ? HELD_S : IDLE_S;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE_S;
    else       state <= stateNext;
  end

  assign digitValid = (state == HELD_S);
endmodule

// File: rtl/digitSteer.sv
`timescale 1ns/1ps
module digitSteer
  import digitSteerPkg::*;
#(
  parameter int CLK_PER_MS = 50000,
  parameter int TICK_W     = 8,
  parameter int CODE_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              toneHit,
  input  logic [CODE_W-1:0] toneCode,
  input  logic [TICK_W-1:0] presentTicks,
  input  logic [TICK_W-1:0] absentTicks,
  input  logic              busEnable,
  output logic              digitValid,
  output logic [CODE_W-1:0] busData,
  output logic              busOe
);
  steerStrobeT       strobe;
  logic [1:0]        runAtEnd;
  logic [CODE_W-1:0] codeLatch;

  digitSteerCtrl uCtrl (
    .clk(clk), .rstN(rstN), .toneHit(toneHit), .runAtEnd(runAtEnd),
    .strobe(strobe), .digitValid(digitValid)
  );

  digitSteerData #(.CLK_PER_MS(CLK_PER_MS), .TICK_W(TICK_W), .CODE_W(CODE_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .toneCode(toneCode),
    .presentTicks(presentTicks), .absentTicks(absentTicks), .busEnable(busEnable),
    .runAtEnd(runAtEnd), .codeLatch(codeLatch), .busData(busData), .busOe(busOe)
  );
endmodule

// File: rtl/digitSteerChk.sv
`timescale 1ns/1ps
module digitSteerChk #(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              toneHit,
  input logic [CODE_W-1:0] toneCode,
  input logic              digitValid,
  input logic [CODE_W-1:0] codeLatch
);
  AST_RISE_AFTER_HIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(digitValid) |-> $past(toneHit)); // R2
  AST_LATCH_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(codeLatch) |-> $rose(digitValid)); // R3
  AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(digitValid) |-> (codeLatch == $past(toneCode))); // R4
  AST_NO_DROPOUT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    ($past(digitValid) && $past(toneHit)) |-> digitValid); // R5
  AST_FALL_AFTER_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(digitValid) |-> !$past(toneHit)); // R6
  AST_HOLD_WHILE_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (digitValid && $past(digitValid)) |-> $stable(codeLatch)); // R7
endmodule

bind digitSteer digitSteerChk #(.CODE_W(CODE_W)) uChk (
  .clk(clk), .rstN(rstN), .toneHit(toneHit), .toneCode(toneCode),
  .digitValid(digitValid), .codeLatch(codeLatch)
);

// File: tb/digitSteer_test.sv
`timescale 1ns/1ps
module digitSteer_test;
  localparam int K = 4;
  localparam int TW = 8;

  logic clk = 0, rstN = 0, toneHit = 0, busEnable = 0;
  logic [3:0] toneCode = 0;
  logic [TW-1:0] presentTicks = 3, absentTicks = 2;
  logic digitValid, busOe;
  logic [3:0] busData;

  int nChecks = 0, nFails = 0;
  bit mValid = 0;
  int mRun = 0;
  logic [3:0] mCode = 0;

  always #10 clk = ~clk;

  digitSteer #(.CLK_PER_MS(K), .TICK_W(TW), .CODE_W(4)) uut (
    .clk(clk), .rstN(rstN), .toneHit(toneHit), .toneCode(toneCode),
    .presentTicks(presentTicks), .absentTicks(absentTicks), .busEnable(busEnable),
    .digitValid(digitValid), .busData(busData), .busOe(busOe)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural run-length model, updated on each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mValid = 0; mRun = 0; mCode = 0;
    end else begin
      int need;
      need = mValid ? int'(absentTicks) : int'(presentTicks);
      if (need == 0) need = 1;
      if (mValid ? !toneHit : toneHit) begin
        mRun++;
        if (mRun == need * K) begin
          if (!mValid) mCode = toneCode;
          mValid = !mValid;
          mRun = 0;
        end
      end else mRun = 0;
    end
  end

  // per-cycle comparison against the model
  initial forever begin
    @(negedge clk); #4;
    if (rstN) begin
      chk(digitValid === mValid, mValid ? "R6" : "R2", "model digitValid", digitValid, mValid);
      chk(busOe === busEnable, "R8", "model busOe", busOe, busEnable);
      chk(busData === (busEnable ? mCode : 4'd0), "R4", "model busData", busData,
          busEnable ? mCode : 0);
    end
  end

  task automatic drive(input logic hit, input logic [3:0] code, input int n);
    for (int i = 0; i < n; i++) begin
      toneHit = hit; toneCode = code;
      @(negedge clk);
    end
  endtask

  task automatic expectOut(input string tag, input logic v, input logic [3:0] d);
    #1;
    chk(digitValid === v, tag, "digitValid", digitValid, v);
    chk(busData === d, tag, "busData", busData, d);
    chk(busOe === busEnable, tag, "busOe", busOe, busEnable);
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expectOut("R1", 1'b0, 4'd0);          // during reset, bus disabled
    rstN = 1;
    @(negedge clk);
    busEnable = 1;
    expectOut("R1", 1'b0, 4'd0);          // reset code visible as zero

    // R3: burst one cycle short of 12
    drive(1, 4'd5, 11);
    expectOut("R3", 1'b0, 4'd0);
    drive(0, 4'd5, 2);
    // R3: two runs of 8 split by one low sample
    drive(1, 4'd5, 8); drive(0, 4'd5, 1); drive(1, 4'd5, 8);
    expectOut("R3", 1'b0, 4'd0);
    drive(0, 4'd5, 2);

    // R2/R4: boundary of the present guard
    drive(1, 4'd5, 11);
    expectOut("R2", 1'b0, 4'd0);
    drive(1, 4'd5, 1);
    expectOut("R2", 1'b1, 4'd5);
    expectOut("R4", 1'b1, 4'd5);

    // R7: code changes while held
    drive(1, 4'd9, 4);
    expectOut("R7", 1'b1, 4'd5);
    // R5: drop-outs shorter than 8
    drive(0, 4'd9, 7);
    expectOut("R5", 1'b1, 4'd5);
    drive(1, 4'd9, 1); drive(0, 4'd9, 7);
    expectOut("R5", 1'b1, 4'd5);
    // R6: eighth consecutive low
    drive(0, 4'd9, 1);
    expectOut("R6", 1'b0, 4'd5);

    // R9/R8: register while bus disabled
    busEnable = 0;
    drive(1, 4'd10, 12);
    expectOut("R8", 1'b1, 4'd0);
    busEnable = 1;
    expectOut("R9", 1'b1, 4'd10);
    drive(0, 4'd10, 8);
    expectOut("R6", 1'b0, 4'd10);

    // R2: zero setting acts as one tick (4 cycles)
    presentTicks = 0;
    drive(1, 4'd3, 3);
    expectOut("R2", 1'b0, 4'd10);
    drive(1, 4'd3, 1);
    expectOut("R2", 1'b1, 4'd3);
    drive(0, 4'd3, 8);
    expectOut("R6", 1'b0, 4'd3);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule